// File: doc/BRIEF.md
# Nine-Operand Popcount Column Compressor

This block adds nine equally weighted unsigned W-bit words, such as the nine products of a 3×3 convolution window, plus two extra injection words. It does not produce a single binary sum. It produces two vectors: a sum vector and a carry vector. Their arithmetic total equals the total of all inputs. The final carry-propagate addition is left to the consumer, which can defer it (for example, across many accumulation cycles) and fold the two vectors back in through the injection lanes.

The network works column by column. Each column of input bits is counted by a popcount counter. The bits of every count are placed back into the columns of matching weight. A second counting layer shrinks every column to three bits, and a final full-adder stage turns them into one sum bit and one carry bit. No signal travels more than three columns sideways. The logic depth therefore depends only on the three counter layers and not on the word width. The outputs are W+G bits wide, and G guard columns absorb the growth of the sum. The outputs can be registered or left combinational.

Top module: `hwc_compressor`

## Requirements
- R1: For any inputs, sum(gen_o[i]·2^i) + sum(car_o[i]·2^(i+1)), taken modulo 2^(W+G), equals the sum of the nine operands and both injection words modulo 2^(W+G). The operands are zero-extended, and the injection words are full W+G-bit values.
- R2: When both injection words are zero and G ≥ 4, the two-vector total equals the operand sum exactly, with no wrap. car_o[W+G-1] is then 0. With W=16 and all operands at 16'hFFFF, the total is 589815.
- R3: With REG_OUT=1, the outputs change only at a rising clock edge. They reflect the inputs present at that edge and keep their value while the inputs are held.
- R4: A synchronous active-high reset clears gen_o and car_o to zero at the next rising edge, whatever the inputs.
- R5: A single 1 at bit k of either injection word alone gives a total of 2^k modulo 2^(W+G). A 1 at bit W+G-1 of both words therefore totals 0.
- R6: gen_o[0] equals the XOR of bit 0 of all nine operands and bit 0 of both injection words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| ops_i | input | 9*W | Nine operands; operand m occupies bits [m*W +: W] |
| inj_a_i | input | W+G | First injection word, one bit per column |
| inj_b_i | input | W+G | Second injection word, one bit per column |
| gen_o | output | W+G | Sum vector, bit i weighted 2^i |
| car_o | output | W+G | Carry vector, bit i weighted 2^(i+1) |

## Verification
On every cycle, the checker compares the two-vector total against a behavioural sum of the previous cycle's inputs. It checks the modulo identity and, when the injections are zero, the exact no-wrap result. It also checks the column-0 parity, the reset clearing and the hold behaviour while inputs are stable. Some behaviours only the directed scenarios show: the exact latency relative to a change of inputs, the wrap value for all-ones inputs with full injections, and the weight of each injection lane at its low, middle and top columns.

// File: rtl/hwc_pkg.sv
`timescale 1ns/1ps
package hwc_pkg;
  // Number of equally weighted operand words per column.
  localparam int unsigned NUM_OPS = 9;
  // Extra single-bit injection lanes per column.
  localparam int unsigned NUM_INJ = 2;

  // Bits needed to hold a count of n ones.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/hwc_popcount.sv
`timescale 1ns/1ps
module hwc_popcount #(
  parameter int unsigned N_IN = 9,
  localparam int unsigned OW = hwc_pkg::cnt_bits(N_IN)
) (
  input  logic [N_IN-1:0] bits_i,
  output logic [OW-1:0]   cnt_o
);
  // Behavioural ones-count; synthesis maps it to a shallow counter tree.
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N_IN; i++) begin
      cnt_o = cnt_o + OW'(bits_i[i]);
    end
  end
endmodule

// File: rtl/hwc_count_layer.sv
`timescale 1ns/1ps
module hwc_count_layer #(
  parameter int unsigned COLS    = 20,
  parameter int unsigned HEIGHT  = 11,
  parameter bit          REALIGN = 1'b1,
  localparam int unsigned OW = hwc_pkg::cnt_bits(HEIGHT)
) (
  input  logic [COLS-1:0][HEIGHT-1:0] cols_i,
  output logic [COLS-1:0][OW-1:0]     cols_o
);
  logic [COLS-1:0][OW-1:0] cnt;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    hwc_popcount #(.N_IN(HEIGHT)) u_cnt (
      .bits_i (cols_i[c]),
      .cnt_o  (cnt[c])
    );
  end

  if (REALIGN) begin : g_realign
    // Bit k of every column count moves up k columns; bits pushed past
    // the top column fall off the shift (modulo 2^COLS).
    for (genvar k = 0; k < OW; k++) begin : g_plane
      logic [COLS-1:0] plane;
      logic [COLS-1:0] moved;
      for (genvar c = 0; c < COLS; c++) begin : g_pick
        assign plane[c] = cnt[c][k];
      end
      assign moved = plane << k;
      for (genvar c = 0; c < COLS; c++) begin : g_put
        assign cols_o[c][k] = moved[c];
      end
    end
  end else begin : g_raw
    assign cols_o = cnt;
  end
endmodule

// File: rtl/hwc_compressor.sv
`timescale 1ns/1ps
module hwc_compressor #(
  parameter int unsigned W       = 16,
  parameter int unsigned G       = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [hwc_pkg::NUM_OPS*W-1:0]     ops_i,
  input  logic [W+G-1:0]                    inj_a_i,
  input  logic [W+G-1:0]                    inj_b_i,
  output logic [W+G-1:0]                    gen_o,
  output logic [W+G-1:0]                    car_o
);
  import hwc_pkg::*;

  localparam int unsigned N  = W + G;
  localparam int unsigned H1 = NUM_OPS + NUM_INJ;   // 11 bits per column
  localparam int unsigned H2 = cnt_bits(H1);        // 4 after first layer
  localparam int unsigned H3 = cnt_bits(H2);        // 3 after second layer
  localparam int unsigned H4 = cnt_bits(H3);        // 2: sum and carry

  logic [N-1:0][H1-1:0] l1_cols;
  logic [N-1:0][H2-1:0] l2_cols;
  logic [N-1:0][H3-1:0] l3_cols;
  logic [N-1:0][H4-1:0] fin_cols;
  logic [N-1:0]         gen_d;
  logic [N-1:0]         car_d;

  // Column assembly: operands zero-extended into the guard columns.
  for (genvar c = 0; c < N; c++) begin : g_asm
    for (genvar m = 0; m < NUM_OPS; m++) begin : g_op
      if (c < W) begin : g_live
        assign l1_cols[c][m] = ops_i[m*W + c];
      end else begin : g_guard
        assign l1_cols[c][m] = 1'b0;
      end
    end
    assign l1_cols[c][NUM_OPS]   = inj_a_i[c];
    assign l1_cols[c][NUM_OPS+1] = inj_b_i[c];
  end

  hwc_count_layer #(.COLS(N), .HEIGHT(H1), .REALIGN(1'b1)) u_layer1 (
    .cols_i (l1_cols),
    .cols_o (l2_cols)
  );

  hwc_count_layer #(.COLS(N), .HEIGHT(H2), .REALIGN(1'b1)) u_layer2 (
    .cols_i (l2_cols),
    .cols_o (l3_cols)
  );

  // Final layer: per-column full adder, carry left unshifted.
  hwc_count_layer #(.COLS(N), .HEIGHT(H3), .REALIGN(1'b0)) u_layer3 (
    .cols_i (l3_cols),
    .cols_o (fin_cols)
  );

  for (genvar c = 0; c < N; c++) begin : g_split
    assign gen_d[c] = fin_cols[c][0];
    assign car_d[c] = fin_cols[c][1];
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        gen_o <= '0;
        car_o <= '0;
      end else begin
        gen_o <= gen_d;
        car_o <= car_d;
      end
    end
  end else begin : g_comb
    assign gen_o = gen_d;
    assign car_o = car_d;
  end
endmodule

// File: rtl/hwc_compressor_chk.sv
`timescale 1ns/1ps
module hwc_compressor_chk #(
  parameter int unsigned W       = 16,
  parameter int unsigned G       = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input logic                          clk,
  input logic                          rst,
  input logic [hwc_pkg::NUM_OPS*W-1:0] ops_i,
  input logic [W+G-1:0]                inj_a_i,
  input logic [W+G-1:0]                inj_b_i,
  input logic [W+G-1:0]                gen_o,
  input logic [W+G-1:0]                car_o
);
  localparam int unsigned N = W + G;

  logic [N+1:0] ref_sum;
  logic [N+1:0] obs_sum;
  logic         col0_par;
  logic         inj_zero;
  logic         armed;

  always_comb begin
    ref_sum = (N+2)'(inj_a_i) + (N+2)'(inj_b_i);
    col0_par = inj_a_i[0] ^ inj_b_i[0];
    for (int m = 0; m < hwc_pkg::NUM_OPS; m++) begin
      ref_sum  = ref_sum + (N+2)'(ops_i[m*W +: W]);
      col0_par = col0_par ^ ops_i[m*W];
    end
  end

  assign obs_sum  = (N+2)'(gen_o) + ((N+2)'(car_o) << 1);
  assign inj_zero = (inj_a_i == '0) && (inj_b_i == '0);

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  if (REG_OUT) begin : g_seq
    // R1: two-vector total matches the behavioural sum modulo 2^N
    a_r1_total_mod: assert property (@(posedge clk) disable iff (rst)
      armed |-> obs_sum[N-1:0] == $past(ref_sum[N-1:0]));
    // R2: without injections the total is exact and the top carry is clear
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(inj_zero)) |-> (obs_sum == $past(ref_sum)) && !car_o[N-1]);
    // R3: outputs hold while the inputs are held
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(armed) && $past($stable({ops_i, inj_a_i, inj_b_i})))
        |-> $stable({gen_o, car_o}));
    // R4: reset clears both vectors at the next edge
    a_r4_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (gen_o == '0) && (car_o == '0));
    // R6: lowest sum bit is the parity of column 0
    a_r6_col0_parity: assert property (@(posedge clk) disable iff (rst)
      armed |-> gen_o[0] == $past(col0_par));
  end else begin : g_cmb
    // R1
    a_r1_total_mod: assert property (@(posedge clk) disable iff (rst)
      obs_sum[N-1:0] == ref_sum[N-1:0]);
    // R2
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
      inj_zero |-> (obs_sum == ref_sum) && !car_o[N-1]);
    // R6
    a_r6_col0_parity: assert property (@(posedge clk) disable iff (rst)
      gen_o[0] == col0_par);
  end
endmodule

bind hwc_compressor hwc_compressor_chk #(.W(W), .G(G), .REG_OUT(REG_OUT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ops_i   (ops_i),
  .inj_a_i (inj_a_i),
  .inj_b_i (inj_b_i),
  .gen_o   (gen_o),
  .car_o   (car_o)
);

// File: tb/hwc_compressor_tb.sv
`timescale 1ns/1ps
module hwc_compressor_tb;
  localparam int unsigned W = 16;
  localparam int unsigned G = 4;
  localparam int unsigned N = W + G;
  localparam int unsigned NOPS = 9;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NOPS*W-1:0] ops = '0;
  logic [N-1:0]    inj_a = '0;
  logic [N-1:0]    inj_b = '0;
  logic [N-1:0]    gen_o;
  logic [N-1:0]    car_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;  // 50 MHz

  hwc_compressor #(.W(W), .G(G), .REG_OUT(1'b1)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .ops_i   (ops),
    .inj_a_i (inj_a),
    .inj_b_i (inj_b),
    .gen_o   (gen_o),
    .car_o   (car_o)
  );

  function automatic logic [N+1:0] exp_sum();
    logic [N+1:0] s;
    s = (N+2)'(inj_a) + (N+2)'(inj_b);
    for (int m = 0; m < NOPS; m++) s = s + (N+2)'(ops[m*W +: W]);
    return s;
  endfunction

  function automatic logic exp_par0();
    logic p;
    p = inj_a[0] ^ inj_b[0];
    for (int m = 0; m < NOPS; m++) p = p ^ ops[m*W];
    return p;
  endfunction

  function automatic logic [N+1:0] obs_sum();
    return (N+2)'(gen_o) + ((N+2)'(car_o) << 1);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge register, sample at the next falling edge.
  task automatic apply_and_wait();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    ops = '1; inj_a = '1; inj_b = '1;
    apply_and_wait();
    chk("R4 reset gen", 64'(gen_o), 64'd0);
    chk("R4 reset car", 64'(car_o), 64'd0);
    rst = 1'b0;
    ops = '0; inj_a = '0; inj_b = '0;
    apply_and_wait();
    chk("R1 zero inputs", 64'(obs_sum()), 64'd0);
  endtask

  task automatic t_all_ones();
    ops = '1; inj_a = '0; inj_b = '0;
    apply_and_wait();
    chk("R2 all-ones exact", 64'(obs_sum()), 64'd589815);
    chk("R2 top carry clear", 64'(car_o[N-1]), 64'd0);
    chk("R6 all-ones parity", 64'(gen_o[0]), 64'(exp_par0()));
    inj_a = '1; inj_b = '1;
    apply_and_wait();
    chk("R1 all-ones wrap", 64'(obs_sum() & ((1 << N) - 1)), 64'd589813);
  endtask

  task automatic t_inj_lanes();
    int cols[3] = '{0, 7, N-1};
    ops = '0;
    foreach (cols[i]) begin
      inj_a = N'(1) << cols[i]; inj_b = '0;
      apply_and_wait();
      chk("R5 lane a weight", 64'(obs_sum() & ((1 << N) - 1)), 64'(1) << cols[i]);
      inj_a = '0; inj_b = N'(1) << cols[i];
      apply_and_wait();
      chk("R5 lane b weight", 64'(obs_sum() & ((1 << N) - 1)), 64'(1) << cols[i]);
    end
    inj_a = N'(1) << (N-1); inj_b = N'(1) << (N-1);
    apply_and_wait();
    chk("R5 both top bits wrap", 64'(obs_sum() & ((1 << N) - 1)), 64'd0);
  endtask

  task automatic t_random();
    for (int v = 0; v < 24; v++) begin
      for (int m = 0; m < NOPS; m++) ops[m*W +: W] = W'($urandom);
      if (v % 2 == 0) begin inj_a = '0; inj_b = '0; end
      else begin inj_a = N'($urandom); inj_b = N'($urandom); end
      apply_and_wait();
      chk("R1 random total", 64'(obs_sum() & ((1 << N) - 1)), 64'(exp_sum() & ((1 << N) - 1)));
      if (v % 2 == 0) chk("R2 random exact", 64'(obs_sum()), 64'(exp_sum()));
      chk("R6 random parity", 64'(gen_o[0]), 64'(exp_par0()));
    end
  endtask

  task automatic t_latency();
    logic [63:0] first;
    ops = '0; ops[W-1:0] = 16'd5; inj_a = '0; inj_b = '0;
    apply_and_wait();
    first = 64'(obs_sum());
    chk("R3 first value", first, 64'd5);
    ops[W-1:0] = 16'd300;
    #1;
    chk("R3 unchanged before edge", 64'(obs_sum()), 64'd5);
    apply_and_wait();
    chk("R3 new value after edge", 64'(obs_sum()), 64'd300);
    apply_and_wait();
    chk("R3 held while inputs held", 64'(obs_sum()), 64'd300);
    rst = 1'b1;
    apply_and_wait();
    chk("R4 mid-run reset", 64'({gen_o, car_o}), 64'd0);
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_all_ones();
    t_inj_lanes();
    t_random();
    t_latency();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule